// File: doc/BRIEF.md
# Timer Clock Source Selector and Counter

This block is the front end of a general-purpose timer. A 3-bit slave-mode field picks the source of the pulses that feed the timer prescaler. The sources are the bus clock itself, a quadrature decoder that watches two channel pins, or the rising edges of one trigger input chosen from a set. In the last case the block works as an event counter. The prescaler divides the selected pulses, and each of its output ticks moves an up/down counter by one. The counter wraps at a reload value or at zero and then raises an update event.

Every part runs on the bus clock. The pins are brought in through two-flop synchronizers and turned into single-cycle enables; no derived clock is made. A software update input re-initialises the prescaler and the counter. When the event counter is set to take its trigger from that software bit, asserting the bit updates the counter instead of making it count. Configuration comes in as plain ports.

Top module: `tick_source_timer`

## Requirements
- R1: After synchronous reset, `cnt_value` is 0, `dir_down` is 0 (up) and `update_evt` is 0.
- R2: With `slave_mode` at 0, 4, 5 or 6 and `count_en` high, the prescaler receives one pulse per bus clock. With `count_en` low the counter holds its value in every mode.
- R3: The prescaler emits one counter step for every `psc_val`+1 source pulses, beginning from a cleared prescaler.
- R4: Counting up from a value at or above `reload_val`, the counter goes to 0. Counting down from 0, it loads `reload_val`. Both wraps give a one-cycle `update_evt` pulse in the cycle the new value appears.
- R5: Outside quadrature modes, the counting direction follows `dir_cfg` (0 up, 1 down), and `dir_down` shows `dir_cfg` one clock later.
- R6: With `slave_mode` at 3, every transition of either channel is one source pulse. Channel 0 leading channel 1 counts up; lagging counts down. `dir_down` takes the direction of the last counted transition.
- R7: With `slave_mode` at 1, only channel 0 transitions are counted; with 2, only channel 1 transitions. Either way the direction comes from the level of the other channel, so a full forward cycle adds 2.
- R8: In any quadrature mode, a sample in which both synchronized channels change at once is ignored.
- R9: With `slave_mode` at 7 and `trig_sel` = k (1..NTRIG), each rising edge of `trig_in[k-1]` is one source pulse. Falling edges and the other triggers are ignored.
- R10: With `slave_mode` at 7 and `trig_sel` at 0, no trigger edge makes the counter count; `sw_update` updates it instead.
- R11: A one-cycle `sw_update` in any mode clears the prescaler, loads the counter with 0 (up) or `reload_val` (down), and gives an `update_evt` pulse on the next clock.
- R12: A channel pin change reaches `cnt_value` on the third rising clock edge after the change and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 3 | Source select: 0/4/5/6 bus clock, 1/2/3 quadrature, 7 event counter |
| trig_sel | input | TSEL_W | Event trigger select: 0 software bit, k picks trig_in[k-1] |
| ch0_pin | input | 1 | Quadrature channel 0 |
| ch1_pin | input | 1 | Quadrature channel 1 |
| trig_in | input | NTRIG | Trigger inputs |
| sw_update | input | 1 | Software update request, one-cycle pulse |
| count_en | input | 1 | Counter run enable |
| dir_cfg | input | 1 | Direction for non-quadrature modes, 1 = down |
| psc_val | input | PSC_W | Prescaler divide value minus one |
| reload_val | input | CNT_W | Counter reload value |
| cnt_value | output | CNT_W | Counter value |
| dir_down | output | 1 | Current counting direction, 1 = down |
| update_evt | output | 1 | Update event pulse |

## Verification
The bench drives full quadrature cycles in both phase orders and in all three channel selections. A decoder with swapped direction rules, or one that counts the unselected channel, ends a cycle at the wrong value. It makes both channels change in the same sample, which a decoder without the invalid-transition filter would count. It wraps the counter in both directions, including through zero in quadrature mode, where an off-by-one wrap or a lost update pulse shows up. It also checks that the software trigger selection in event mode gives an update and no count, and that the pin-to-count latency is exactly three edges.

// File: rtl/tick_source_pkg.sv
package tick_source_pkg;

    typedef enum logic [1:0] {
        SRC_BUS   = 2'd0,
        SRC_QUAD  = 2'd1,
        SRC_EVENT = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic pulse;
        logic down;
    } step_t;

    localparam logic [2:0] MODE_EVENT = 3'd7;

    function automatic src_kind_e decode_src(input logic [2:0] mode);
        src_kind_e k;
        case (mode)
            3'd1, 3'd2, 3'd3: k = SRC_QUAD;
            3'd7:             k = SRC_EVENT;
            default:          k = SRC_BUS;
        endcase
        return k;
    endfunction

    // Direction of one valid transition: a change on channel 0 counts up
    // when the new levels differ; a change on channel 1 counts up when they match.
    function automatic logic quad_is_up(input logic a_moved, input logic a, input logic b);
        return a_moved ? (a ^ b) : ~(a ^ b);
    endfunction

endpackage

// File: rtl/tick_sync_edge.sv
module tick_sync_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] stage3;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            stage3 <= '0;
        end else begin
            stage1 <= raw;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign lvl      = stage2;
    assign lvl_prev = stage3;
endmodule

// File: rtl/tick_quad_decoder.sv
module tick_quad_decoder
    import tick_source_pkg::*;
(
    input  logic [1:0] chan_sel,
    input  logic       a,
    input  logic       b,
    input  logic       a_prev,
    input  logic       b_prev,
    output step_t      step
);
    logic a_moved;
    logic b_moved;
    logic single;
    logic use_a;
    logic use_b;

    always_comb begin
        a_moved = a ^ a_prev;
        b_moved = b ^ b_prev;
        single  = a_moved ^ b_moved;
        use_a   = chan_sel[0];
        use_b   = chan_sel[1];
        step.pulse = single & ((a_moved & use_a) | (b_moved & use_b));
        step.down  = ~quad_is_up(a_moved, a, b);
    end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             pulse_in,
    input  logic [PSC_W-1:0] div_m1,
    output logic             tick
);
    logic [PSC_W-1:0] acc;
    logic             at_end;

    always_comb begin
        at_end = (acc >= div_m1);
        tick   = pulse_in & at_end & ~clear;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (pulse_in) begin
            acc <= at_end ? '0 : acc + PSC_W'(1);
        end
    end
endmodule

// File: rtl/tick_updown_counter.sv
module tick_updown_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reinit,
    input  logic             step,
    input  logic             down,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] value,
    output logic             wrap_evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value    <= '0;
            wrap_evt <= 1'b0;
        end else if (reinit) begin
            value    <= down ? reload : '0;
            wrap_evt <= 1'b1;
        end else if (step) begin
            if (down) begin
                if (value == '0) begin
                    value    <= reload;
                    wrap_evt <= 1'b1;
                end else begin
                    value    <= value - CNT_W'(1);
                    wrap_evt <= 1'b0;
                end
            end else begin
                if (value >= reload) begin
                    value    <= '0;
                    wrap_evt <= 1'b1;
                end else begin
                    value    <= value + CNT_W'(1);
                    wrap_evt <= 1'b0;
                end
            end
        end else begin
            wrap_evt <= 1'b0;
        end
    end
endmodule

// File: rtl/tick_source_timer.sv
module tick_source_timer
    import tick_source_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int NTRIG  = 7,
    parameter int TSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        slave_mode,
    input  logic [TSEL_W-1:0] trig_sel,
    input  logic              ch0_pin,
    input  logic              ch1_pin,
    input  logic [NTRIG-1:0]  trig_in,
    input  logic              sw_update,
    input  logic              count_en,
    input  logic              dir_cfg,
    input  logic [PSC_W-1:0]  psc_val,
    input  logic [CNT_W-1:0]  reload_val,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              dir_down,
    output logic              update_evt
);
    localparam int CH_N = 2;

    src_kind_e       kind;
    logic [CH_N-1:0] ch_lvl;
    logic [CH_N-1:0] ch_prev;
    logic [NTRIG-1:0] tr_lvl;
    logic [NTRIG-1:0] tr_prev;
    logic [NTRIG-1:0] tr_rise;
    logic            sel_rise;
    step_t           qstep;
    logic            src_pulse;
    logic            psc_tick;
    logic            dir_reg;
    logic            step_down;

    tick_sync_edge #(.W(CH_N)) i_ch_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      ({ch1_pin, ch0_pin}),
        .lvl      (ch_lvl),
        .lvl_prev (ch_prev)
    );

    tick_sync_edge #(.W(NTRIG)) i_tr_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      (trig_in),
        .lvl      (tr_lvl),
        .lvl_prev (tr_prev)
    );

    assign tr_rise = tr_lvl & ~tr_prev;

    always_comb begin
        sel_rise = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (trig_sel == TSEL_W'(i + 1)) sel_rise = tr_rise[i];
        end
    end

    tick_quad_decoder i_quad (
        .chan_sel (slave_mode[1:0]),
        .a        (ch_lvl[0]),
        .b        (ch_lvl[1]),
        .a_prev   (ch_prev[0]),
        .b_prev   (ch_prev[1]),
        .step     (qstep)
    );

    always_comb begin
        kind = decode_src(slave_mode);
        case (kind)
            SRC_QUAD:  src_pulse = qstep.pulse;
            SRC_EVENT: src_pulse = sel_rise;
            default:   src_pulse = 1'b1;
        endcase
        src_pulse = src_pulse & count_en;
        if (kind == SRC_QUAD) step_down = qstep.pulse ? qstep.down : dir_reg;
        else                  step_down = dir_cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_reg <= 1'b0;
        end else if (kind == SRC_QUAD) begin
            if (count_en && qstep.pulse) dir_reg <= qstep.down;
        end else begin
            dir_reg <= dir_cfg;
        end
    end

    tick_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk      (clk),
        .rst      (rst),
        .clear    (sw_update),
        .pulse_in (src_pulse),
        .div_m1   (psc_val),
        .tick     (psc_tick)
    );

    tick_updown_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .reinit   (sw_update),
        .step     (psc_tick),
        .down     (step_down),
        .reload   (reload_val),
        .value    (cnt_value),
        .wrap_evt (update_evt)
    );

    assign dir_down = dir_reg;
endmodule

// File: rtl/tick_source_timer_chk.sv
module tick_source_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int TSEL_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        slave_mode,
    input logic [TSEL_W-1:0] trig_sel,
    input logic              sw_update,
    input logic              count_en,
    input logic              dir_cfg,
    input logic [CNT_W-1:0]  reload_val,
    input logic [CNT_W-1:0]  cnt_value,
    input logic              dir_down,
    input logic              update_evt
);
    logic non_quad;
    assign non_quad = (slave_mode == 3'd0) || (slave_mode[2] == 1'b1);

    // R2: a stopped counter does not move without a software update
    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !sw_update) |=> $stable(cnt_value));

    // R4: an update event only shows a wrap or reload target
    assert_update_value_R4: assert property (@(posedge clk) disable iff (rst)
        update_evt |-> (cnt_value == '0 || cnt_value == $past(reload_val)));

    // R4: without an update the counter moves by at most one
    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        !update_evt |-> (cnt_value == $past(cnt_value)
                      || cnt_value == CNT_W'($past(cnt_value) + 1)
                      || cnt_value == CNT_W'($past(cnt_value) - 1)));

    // R5: outside quadrature modes the direction follows the configuration
    assert_dir_follows_cfg_R5: assert property (@(posedge clk) disable iff (rst)
        non_quad |=> (dir_down == $past(dir_cfg)));

    // R10: software trigger selection in event mode never counts
    assert_no_count_sw_trigger_R10: assert property (@(posedge clk) disable iff (rst)
        (slave_mode == 3'd7 && trig_sel == '0 && !sw_update) |=> $stable(cnt_value));

    // R11: software update always produces an update event
    assert_sw_update_evt_R11: assert property (@(posedge clk) disable iff (rst)
        sw_update |=> update_evt);
endmodule

bind tick_source_timer tick_source_timer_chk #(.CNT_W(CNT_W), .TSEL_W(TSEL_W)) i_chk (.*);

// File: tb/test_tick_source_timer.sv
`timescale 1ns/1ps
module test_tick_source_timer;
    localparam int CNT_W  = 16;
    localparam int PSC_W  = 16;
    localparam int NTRIG  = 7;
    localparam int TSEL_W = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic [2:0]        slave_mode;
    logic [TSEL_W-1:0] trig_sel;
    logic              ch0_pin;
    logic              ch1_pin;
    logic [NTRIG-1:0]  trig_in;
    logic              sw_update;
    logic              count_en;
    logic              dir_cfg;
    logic [PSC_W-1:0]  psc_val;
    logic [CNT_W-1:0]  reload_val;
    logic [CNT_W-1:0]  cnt_value;
    logic              dir_down;
    logic              update_evt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tick_source_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .NTRIG(NTRIG), .TSEL_W(TSEL_W)) i_tick_source_timer (
        .clk(clk), .rst(rst), .slave_mode(slave_mode), .trig_sel(trig_sel),
        .ch0_pin(ch0_pin), .ch1_pin(ch1_pin), .trig_in(trig_in),
        .sw_update(sw_update), .count_en(count_en), .dir_cfg(dir_cfg),
        .psc_val(psc_val), .reload_val(reload_val),
        .cnt_value(cnt_value), .dir_down(dir_down), .update_evt(update_evt)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sw_pulse();
        sw_update = 1'b1;
        tick(1);
        sw_update = 1'b0;
    endtask

    task automatic pins(input logic a, input logic b);
        ch0_pin = a;
        ch1_pin = b;
        tick(4);
    endtask

    task automatic quad_fwd();
        pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
    endtask

    task automatic quad_rev();
        pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
    endtask

    task automatic t_reset();
        chk("R1 cnt", int'(cnt_value), 0);
        chk("R1 dir", int'(dir_down), 0);
        chk("R1 update", int'(update_evt), 0);
    endtask

    task automatic t_internal();
        slave_mode = 3'd0;
        count_en = 1'b1;
        tick(10);
        chk("R2 mode0 count", int'(cnt_value), 10);
        count_en = 1'b0;
        tick(5);
        chk("R2 hold", int'(cnt_value), 10);
        slave_mode = 3'd4;
        count_en = 1'b1;
        tick(3);
        slave_mode = 3'd6;
        tick(2);
        count_en = 1'b0;
        chk("R2 modes 4 and 6", int'(cnt_value), 15);
    endtask

    task automatic t_prescale();
        sw_pulse();
        chk("R11 reinit up", int'(cnt_value), 0);
        chk("R11 update", int'(update_evt), 1);
        psc_val = 16'd2;
        count_en = 1'b1;
        tick(8);
        chk("R3 div3 after 8", int'(cnt_value), 2);
        tick(1);
        chk("R3 div3 after 9", int'(cnt_value), 3);
        count_en = 1'b0;
        psc_val = '0;
    endtask

    task automatic t_wrap();
        reload_val = 16'd5;
        dir_cfg = 1'b0;
        sw_pulse();
        count_en = 1'b1;
        tick(5);
        chk("R4 up at reload", int'(cnt_value), 5);
        chk("R4 no update yet", int'(update_evt), 0);
        tick(1);
        chk("R4 overflow value", int'(cnt_value), 0);
        chk("R4 overflow update", int'(update_evt), 1);
        count_en = 1'b0;
        dir_cfg = 1'b1;
        tick(1);
        chk("R5 dir follows cfg", int'(dir_down), 1);
        sw_pulse();
        chk("R11 reinit down", int'(cnt_value), 5);
        count_en = 1'b1;
        tick(5);
        chk("R4 down at zero", int'(cnt_value), 0);
        tick(1);
        chk("R4 underflow value", int'(cnt_value), 5);
        chk("R4 underflow update", int'(update_evt), 1);
        count_en = 1'b0;
        dir_cfg = 1'b0;
        reload_val = 16'd100;
        sw_pulse();
        tick(1);
        chk("R5 dir back up", int'(dir_down), 0);
    endtask

    task automatic t_quad_both();
        slave_mode = 3'd3;
        count_en = 1'b1;
        quad_fwd();
        chk("R6 forward", int'(cnt_value), 4);
        chk("R6 dir up", int'(dir_down), 0);
        quad_rev();
        chk("R6 reverse", int'(cnt_value), 0);
        chk("R6 dir down", int'(dir_down), 1);
        quad_rev();
        chk("R4 quad underflow", int'(cnt_value), 97);
        quad_fwd();
        chk("R4 quad overflow", int'(cnt_value), 0);
        ch0_pin = 1'b1;
        tick(2);
        chk("R12 not before third edge", int'(cnt_value), 0);
        tick(1);
        chk("R12 third edge", int'(cnt_value), 1);
        tick(3);
        pins(1, 1); pins(0, 1); pins(0, 0);
        chk("R6 second forward", int'(cnt_value), 4);
        sw_pulse();
    endtask

    task automatic t_quad_single();
        slave_mode = 3'd1;
        quad_fwd();
        chk("R7 ch0 only", int'(cnt_value), 2);
        slave_mode = 3'd2;
        quad_fwd();
        chk("R7 ch1 only", int'(cnt_value), 4);
        slave_mode = 3'd1;
        quad_rev();
        chk("R7 ch0 reverse", int'(cnt_value), 2);
        chk("R7 dir down", int'(dir_down), 1);
    endtask

    task automatic t_invalid();
        slave_mode = 3'd3;
        pins(1, 1);
        pins(0, 0);
        chk("R8 both change ignored", int'(cnt_value), 2);
    endtask

    task automatic t_event();
        slave_mode = 3'd7;
        trig_sel = 3'd2;
        sw_pulse();
        for (int i = 0; i < 3; i++) begin
            trig_in[1] = 1'b1; tick(3);
            trig_in[1] = 1'b0; tick(3);
        end
        for (int i = 0; i < 2; i++) begin
            trig_in[0] = 1'b1; tick(3);
            trig_in[0] = 1'b0; tick(3);
        end
        chk("R9 selected rising edges", int'(cnt_value), 3);
        trig_sel = 3'd0;
        trig_in[1] = 1'b1; tick(3);
        trig_in[1] = 1'b0; tick(3);
        chk("R10 no count on sw select", int'(cnt_value), 3);
        sw_pulse();
        chk("R10 sw update value", int'(cnt_value), 0);
        chk("R10 sw update event", int'(update_evt), 1);
        count_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        slave_mode = '0; trig_sel = '0; ch0_pin = 1'b0; ch1_pin = 1'b0;
        trig_in = '0; sw_update = 1'b0; count_en = 1'b0; dir_cfg = 1'b0;
        psc_val = '0; reload_val = 16'd100;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_internal();
        t_prescale();
        t_wrap();
        t_quad_both();
        t_quad_single();
        t_invalid();
        t_event();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule